// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block is a two-channel interval timer that generates periodic interrupts from externally supplied tick pulses. Each channel holds an 8-bit divider. At every tick from its chosen source it counts down, and after `divider` ticks it reloads and latches a sticky interrupt flag. A single packed control word configures both channels at once. Each channel slice carries a divider, a hold/run mode, a clock-source select and a one-shot interrupt-clear action. Software acknowledges an interrupt by rewriting the whole control word from a shadow copy with the clear action set for that channel.

The live down-count of channel 0 is always visible on a data port. Software can therefore find the time already spent in the current period as `(divider - count) * period / divider`. For example, a 25 kHz tick with a divider of 250 gives a 100 Hz period, and a 19.2 kHz tick with a divider of 192 also gives 100 Hz. A separate mask-set register enables channels onto the combined interrupt output.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every count is 0, every channel is in hold mode with divider 0 and source 0, no interrupt flag is pending, every mask bit is clear and `irq_out` is low.
- R2: A control write whose mode bit is 0 (hold) loads that channel's divider into its counter at the write edge. While the mode stays hold, the counter keeps that value whatever ticks arrive.
- R3: In run mode (mode bit 1), the counter drops by exactly one at each clock edge where the selected tick input is high. With no selected tick it keeps its value.
- R4: A run-mode channel whose count is 1 and that sees a selected tick reloads its divider and sets its interrupt flag at the same edge. The period is therefore `divider` ticks.
- R5: A divider of 0 acts as 256. The counter holds 0 in hold mode and goes from 0 to 255 on the first tick in run mode.
- R6: The 2-bit source field of a channel picks `tick_src[field]` as its only tick. Pulses on the other three inputs have no effect on that channel.
- R7: A control write with a channel's clear bit at 1 clears that channel's flag. With the clear bit at 0 the flag is left as it was. An expiry in the same cycle as a clear leaves the flag set. Flags are never cleared any other way.
- R8: A write with `reg_addr`=1 ORs `reg_wdata[1:0]` into the mask; a 0 bit never clears a mask bit. `irq_out` is the OR over channels of flag AND mask bit.
- R9: A control write in run mode with a new divider does not disturb the running count. The new divider is used from the next reload onward.
- R10: Control word layout for channel n, with base 12*n: bits base+7..base+0 are the divider, bit base+8 is the mode, bit base+9 is the clear action and bits base+11..base+10 are the source select. A control write uses `reg_addr`=0, and a control write takes effect in that same cycle's tick evaluation.
- R11: The two channels count and flag independently. `irq_pending[n]` shows channel n's flag directly, whatever the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_src | input | 4 | Four tick-enable pulse inputs, one cycle wide |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = mask set |
| reg_wdata | input | 24 | Write data |
| live_count | output | 8 | Current count of channel 0 |
| irq_pending | output | 2 | Sticky interrupt flag per channel |
| irq_out | output | 1 | Masked, combined interrupt |

## Verification
The assertions assume that tick inputs are single-cycle enables sampled at the clock edge and that only one register write arrives per cycle. They also assume that mask bits above the channel count are don't-care. The step-by-one and reload properties expect every count change outside a write cycle to be either a decrement or a reload from 1. Every random control word is therefore built from the documented field layout. Random ticks on all four inputs each cycle exercise the mixes of selected and unselected sources. Writes are kept sparse so that counters run through whole periods, and the clear bits are randomized so that clear-with-expiry collisions do occur.

// File: rtl/dit_pkg.sv
package dit_pkg;
   // Register address decode
   typedef enum logic {
      ADDR_CTRL = 1'b0,
      ADDR_MASK = 1'b1
   } dit_addr_e;

   // Channel mode bit
   typedef enum logic {
      MODE_HOLD = 1'b0,
      MODE_RUN  = 1'b1
   } dit_mode_e;

   // Interrupt action bit
   typedef enum logic {
      ACT_KEEP  = 1'b0,
      ACT_CLEAR = 1'b1
   } dit_act_e;
endpackage

// File: rtl/dit_tick_mux.sv
module dit_tick_mux #(
   parameter int SEL_W = 2
) (
   input  logic [(1<<SEL_W)-1:0] src,
   input  logic [SEL_W-1:0]      sel,
   output logic                  tick
);
   localparam int NSRC = 1 << SEL_W;

   generate
      if (NSRC == 2) begin : g_pair
         assign tick = sel[0] ? src[1] : src[0];
      end else begin : g_wide
         always_comb begin
            tick = 1'b0;
            for (int i = 0; i < NSRC; i++) begin
               if (sel == SEL_W'(i)) tick = src[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dit_channel.sv
module dit_channel
   import dit_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int SEL_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [(1<<SEL_W)-1:0] ticks,
   input  logic                  cfg_we,
   input  logic [DIV_W-1:0]      cfg_div,
   input  logic                  cfg_run,
   input  logic                  cfg_clr,
   input  logic [SEL_W-1:0]      cfg_sel,
   output logic [DIV_W-1:0]      count,
   output logic                  pending
);
   localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

   logic [DIV_W-1:0] div_q, cnt_q, cnt_d;
   dit_mode_e        mode_q, mode_eff;
   logic [SEL_W-1:0] sel_q, sel_eff;
   logic [DIV_W-1:0] div_eff;
   logic             pend_q, tick_sel, expire, clr_req;

   // A write takes effect in the same cycle's evaluation
   assign div_eff  = cfg_we ? cfg_div : div_q;
   assign mode_eff = cfg_we ? dit_mode_e'(cfg_run) : mode_q;
   assign sel_eff  = cfg_we ? cfg_sel : sel_q;
   assign clr_req  = cfg_we && (dit_act_e'(cfg_clr) == ACT_CLEAR);

   dit_tick_mux #(.SEL_W(SEL_W)) u_mux (
      .src  (ticks),
      .sel  (sel_eff),
      .tick (tick_sel)
   );

   assign expire = (mode_eff == MODE_RUN) && tick_sel && (cnt_q == ONE);

   always_comb begin
      if (mode_eff == MODE_HOLD)  cnt_d = div_eff;
      else if (!tick_sel)         cnt_d = cnt_q;
      else if (cnt_q == ONE)      cnt_d = div_eff;
      else                        cnt_d = cnt_q - ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         mode_q <= MODE_HOLD;
         sel_q  <= '0;
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (cfg_we) begin
            div_q  <= cfg_div;
            mode_q <= dit_mode_e'(cfg_run);
            sel_q  <= cfg_sel;
         end
         cnt_q  <= cnt_d;
         pend_q <= expire | (pend_q & ~clr_req);
      end
   end

   assign count   = cnt_q;
   assign pending = pend_q;
endmodule

// File: rtl/dit_irq_gate.sv
module dit_irq_gate #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we,
   input  logic [NUM_CH-1:0] mask_bits,
   input  logic [NUM_CH-1:0] pending,
   output logic              irq
);
   logic [NUM_CH-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_q | mask_bits;
   end

   assign irq = |(pending & mask_q);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
   import dit_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DIV_W  = 8,
   parameter int SEL_W  = 2,
   localparam int FIELD_W = DIV_W + 2 + SEL_W,
   localparam int CTRL_W  = NUM_CH * FIELD_W,
   localparam int NSRC    = 1 << SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   tick_src,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [CTRL_W-1:0] reg_wdata,
   output logic [DIV_W-1:0]  live_count,
   output logic [NUM_CH-1:0] irq_pending,
   output logic              irq_out
);
   localparam int RUN_POS = DIV_W;
   localparam int CLR_POS = DIV_W + 1;
   localparam int SEL_POS = DIV_W + 2;

   generate
      if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
         $error("NUM_CH must be 1..8");
      end
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must be at least 2");
      end
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("SEL_W must be 1..4");
      end
   endgenerate

   logic ctrl_we, mask_we;
   assign ctrl_we = reg_wr && (dit_addr_e'(reg_addr) == ADDR_CTRL);
   assign mask_we = reg_wr && (dit_addr_e'(reg_addr) == ADDR_MASK);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [FIELD_W-1:0] slice;
      logic [DIV_W-1:0]   cnt_w;
      assign slice = reg_wdata[ch*FIELD_W +: FIELD_W];

      dit_channel #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .ticks   (tick_src),
         .cfg_we  (ctrl_we),
         .cfg_div (slice[DIV_W-1:0]),
         .cfg_run (slice[RUN_POS]),
         .cfg_clr (slice[CLR_POS]),
         .cfg_sel (slice[SEL_POS +: SEL_W]),
         .count   (cnt_w),
         .pending (irq_pending[ch])
      );

      if (ch == 0) begin : g_live
         assign live_count = cnt_w;
      end else begin : g_hidden
         logic [DIV_W-1:0] cnt_unused;
         assign cnt_unused = cnt_w;
      end
   end

   dit_irq_gate #(.NUM_CH(NUM_CH)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .mask_we   (mask_we),
      .mask_bits (reg_wdata[NUM_CH-1:0]),
      .pending   (irq_pending),
      .irq       (irq_out)
   );
endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
   parameter int NUM_CH = 2,
   parameter int DIV_W  = 8,
   parameter int SEL_W  = 2
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic                                 reg_wr,
   input logic                                 reg_addr,
   input logic [NUM_CH*(DIV_W+2+SEL_W)-1:0]    reg_wdata,
   input logic [DIV_W-1:0]                     live_count,
   input logic [NUM_CH-1:0]                    irq_pending,
   input logic                                 irq_out
);
   localparam int FW = DIV_W + 2 + SEL_W;
   localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

   logic ctrl_wr;
   assign ctrl_wr = reg_wr && !reg_addr;

   // R2: hold-mode write loads the divider into channel 0
   assert_hold_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !reg_wdata[DIV_W]) |=> (live_count == $past(reg_wdata[DIV_W-1:0])));

   // R3: outside writes the count only steps down by one or reloads from 1
   assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(reg_wr) && (live_count != $past(live_count))) |->
         ((live_count == $past(live_count) - ONE) || ($past(live_count) == ONE)));

   // R4: channel 0 flag rises only from a count of 1
   assert_expire_at_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pending[0]) |-> ($past(live_count) == ONE));

   // R7: flags stay set unless a clear action is written
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sticky
      assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_pending[ch] && !(ctrl_wr && reg_wdata[ch*FW + DIV_W + 1])) |=> irq_pending[ch]);
   end

   // R8: combined output needs a pending flag
   assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (|irq_pending));
endmodule

bind dual_interval_timer dit_checker #(
   .NUM_CH (NUM_CH),
   .DIV_W  (DIV_W),
   .SEL_W  (SEL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .live_count  (live_count),
   .irq_pending (irq_pending),
   .irq_out     (irq_out)
);

// File: tb/sim_dual_interval_timer.sv
`timescale 1ns/1ps
module sim_dual_interval_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  tick_src = '0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [23:0] reg_wdata = '0;
   logic [7:0]  live_count;
   logic [1:0]  irq_pending;
   logic        irq_out;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // reference state
   logic [7:0] m_div [2];
   logic       m_run [2];
   logic [1:0] m_sel [2];
   logic [7:0] m_cnt [2];
   logic [1:0] m_pend = '0;
   logic [1:0] m_mask = '0;

   always #2.5 clk = ~clk;

   dual_interval_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .live_count(live_count),
      .irq_pending(irq_pending), .irq_out(irq_out)
   );

   // R10 layout: per channel 12 bits {sel[1:0], clr, run, div[7:0]}
   function automatic logic [23:0] mk(input logic [7:0] d0, input logic r0, input logic c0,
                                      input logic [1:0] s0, input logic [7:0] d1,
                                      input logic r1, input logic c1, input logic [1:0] s1);
      return {s1, c1, r1, d1, s0, c0, r0, d0};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model(input logic wr, input logic addr, input logic [23:0] wd,
                        input logic [3:0] tk);
      for (int ch = 0; ch < 2; ch++) begin
         logic [11:0] f;
         logic we, r, clr, t, ex;
         logic [7:0] d, nc;
         logic [1:0] s;
         f   = wd[ch*12 +: 12];
         we  = wr && !addr;
         d   = we ? f[7:0]   : m_div[ch];
         r   = we ? f[8]     : m_run[ch];
         s   = we ? f[11:10] : m_sel[ch];
         clr = we && f[9];
         t   = tk[s];
         ex  = 1'b0;
         if (!r) nc = d;
         else if (t) begin
            if (m_cnt[ch] == 8'd1) begin nc = d; ex = 1'b1; end
            else nc = m_cnt[ch] - 8'd1;
         end else nc = m_cnt[ch];
         m_cnt[ch]  = nc;
         m_pend[ch] = ex | (m_pend[ch] & !clr);
         if (we) begin m_div[ch] = f[7:0]; m_run[ch] = f[8]; m_sel[ch] = f[11:10]; end
      end
      if (wr && addr) m_mask = m_mask | wd[1:0];
   endtask

   // drive at negedge, model at posedge, compare at next negedge
   task automatic step(input string tag, input logic wr, input logic addr,
                       input logic [23:0] wd, input logic [3:0] tk);
      reg_wr = wr; reg_addr = addr; reg_wdata = wd; tick_src = tk;
      @(posedge clk);
      model(wr, addr, wd, tk);
      @(negedge clk);
      chk({tag, " count"}, int'(live_count), int'(m_cnt[0]));
      chk({tag, " pend"}, int'(irq_pending), int'(m_pend));
      chk({tag, " irq"}, int'(irq_out), int'(|(m_pend & m_mask)));
      reg_wr = 1'b0; tick_src = '0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int ch = 0; ch < 2; ch++) begin
         m_div[ch] = '0; m_run[ch] = 1'b0; m_sel[ch] = '0; m_cnt[ch] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 count", int'(live_count), 0);
      chk("R1 pend", int'(irq_pending), 0);
      chk("R1 irq", int'(irq_out), 0);

      step("R8 mask set ch0", 1, 1, 24'h1, 4'h0);
      // R2 hold load, R10 layout: ch0 div 5 src0, ch1 div 3 src1
      step("R2 load", 1, 0, mk(8'd5, 0, 0, 2'd0, 8'd3, 0, 0, 2'd1), 4'h0);
      chk("R2 loaded", int'(live_count), 5);
      for (int i = 0; i < 3; i++) step("R2 hold", 0, 0, 24'h0, 4'hF);
      chk("R2 held", int'(live_count), 5);
      step("R3 run", 1, 0, mk(8'd5, 1, 0, 2'd0, 8'd3, 1, 0, 2'd1), 4'h0);
      // R6: only unselected sources for ch0; ch1 counts on src1 (R11)
      for (int i = 0; i < 2; i++) step("R6 other src", 0, 0, 24'h0, 4'b1110);
      chk("R6 unchanged", int'(live_count), 5);
      step("R3 tick", 0, 0, 24'h0, 4'b0001);
      chk("R3 dec", int'(live_count), 4);
      for (int i = 0; i < 3; i++) step("R3 tick", 0, 0, 24'h0, 4'b0001);
      chk("R3 at one", int'(live_count), 1);
      step("R4 expire", 0, 0, 24'h0, 4'b0001);
      chk("R4 reload", int'(live_count), 5);
      chk("R4 flag", int'(irq_pending[0]), 1);
      chk("R4 irq", int'(irq_out), 1);
      step("R7 keep", 1, 0, mk(8'd5, 1, 0, 2'd0, 8'd3, 1, 0, 2'd1), 4'h0);
      chk("R7 keep flag", int'(irq_pending[0]), 1);
      step("R7 clear", 1, 0, mk(8'd5, 1, 1, 2'd0, 8'd3, 1, 0, 2'd1), 4'h0);
      chk("R7 cleared", int'(irq_pending[0]), 0);
      step("R11 ch1 expire", 0, 0, 24'h0, 4'b0010);
      chk("R11 ch1 flag", int'(irq_pending[1]), 1);
      chk("R8 masked", int'(irq_out), 0);
      step("R8 mask ch1", 1, 1, 24'h2, 4'h0);
      chk("R8 unmasked", int'(irq_out), 1);
      step("R8 zero write", 1, 1, 24'h0, 4'h0);
      chk("R8 mask kept", int'(irq_out), 1);
      step("R7 clear ch1", 1, 0, mk(8'd5, 1, 0, 2'd0, 8'd3, 1, 1, 2'd1), 4'h0);
      for (int i = 0; i < 4; i++) step("R3 tick", 0, 0, 24'h0, 4'b0001);
      step("R7 clear+expire", 1, 0, mk(8'd5, 1, 1, 2'd0, 8'd3, 1, 0, 2'd1), 4'b0001);
      chk("R7 expiry wins", int'(irq_pending[0]), 1);
      step("R9 tick", 0, 0, 24'h0, 4'b0001);
      step("R9 new div", 1, 0, mk(8'd9, 1, 0, 2'd0, 8'd3, 1, 0, 2'd1), 4'h0);
      chk("R9 count kept", int'(live_count), 4);
      for (int i = 0; i < 4; i++) step("R9 run", 0, 0, 24'h0, 4'b0001);
      chk("R9 new reload", int'(live_count), 9);
      step("R5 hold zero", 1, 0, mk(8'd0, 0, 0, 2'd0, 8'd3, 1, 0, 2'd1), 4'h0);
      chk("R5 zero", int'(live_count), 0);
      step("R5 run", 1, 0, mk(8'd0, 1, 0, 2'd0, 8'd3, 1, 0, 2'd1), 4'h0);
      step("R5 tick", 0, 0, 24'h0, 4'b0001);
      chk("R5 wrap", int'(live_count), 255);

      // random phase checked against the reference (R3 R4 R6 R7 R9 R11)
      for (int i = 0; i < 4000; i++) begin
         logic wr, addr;
         logic [23:0] wd;
         logic [7:0] d0, d1;
         wr   = ($urandom % 12) == 0;
         addr = ($urandom % 5) == 0;
         d0   = 8'($urandom % 7);
         d1   = 8'($urandom % 7);
         wd   = mk(d0, ($urandom % 4) != 0, 1'($urandom), 2'($urandom),
                   d1, ($urandom % 4) != 0, 1'($urandom), 2'($urandom));
         step("R3 R4 R6 R7 random", wr, addr, wd, 4'($urandom));
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule